// File: doc/BRIEF.md
# Write Strobe Qualifier for a Parallel Memory Port

This block is the write front end of a memory that sits on an asynchronous parallel bus. It samples the active-low chip-select, write-strobe and read-enable pins, the address and data buses, and a digital supply-good flag with a fast system clock. Every pin passes through two flip-flop stages before any decision is made. Inside the clock domain, the block forms a combined strobe that is active while both chip-select and write-strobe are low. It then turns each qualified combined pulse into exactly one single-cycle write event. The event carries an address and a data word.

The address is taken when the combined strobe becomes active, which is the later of the two falling edges. The data is the last value sampled before the combined strobe ends, which is the first of the two rising edges. A pulse is dropped in any of these cases:
- it is shorter than a minimum number of clock cycles;
- the read-enable pin is low at any point while it is active;
- the supply is not good;
- the power-on lockout has not yet expired.

The lockout is a counter that starts when the synchronised supply-good flag goes high. It is cleared whenever that flag goes low. Downstream logic, such as a page buffer, consumes the write events.

Top module: `wr_strobe_front`

## Requirements
- R1: After reset, `wr_valid` is low and stays low until a qualified pulse completes.
- R2: A combined pulse (`ce_n` and `we_n` both low) with `oe_n` high, supply good, lockout expired and a width of at least `MIN_LOW` cycles produces a write event 3 to 5 clock cycles after the first strobe pin rises.
- R3: If `oe_n` is low at any sampled point of the combined pulse, or at its end, no write event is produced.
- R4: `wr_addr` equals the address present when the second of the two strobes falls. A later address change during the pulse is ignored. This holds whichever of the two strobes falls first.
- R5: `wr_data` equals the data present just before the first of the two strobes rises. Earlier data and later data are ignored. This holds whichever of the two strobes rises first.
- R6: A combined pulse shorter than `MIN_LOW` clock cycles produces no write event. A pulse of exactly `MIN_LOW` cycles produces one.
- R7: While `pwr_good` is low, no write event is produced.
- R8: After `pwr_good` rises, pulses that end within `POR_CYCLES` cycles of the synchronised rise produce no write event. Later pulses are accepted.
- R9: Each qualified pulse produces exactly one event, and `wr_valid` is high for exactly one cycle.
- R10: If `pwr_good` falls during a pulse, that pulse is dropped, and the lockout restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select pin, active low, asynchronous |
| we_n | input | 1 | Write strobe pin, active low, asynchronous |
| oe_n | input | 1 | Read enable pin, active low; low inhibits writes |
| addr | input | AW | Address bus pins |
| data | input | DW | Data bus pins |
| pwr_good | input | 1 | Digital supply-good flag |
| wr_valid | output | 1 | Single-cycle write event |
| wr_addr | output | AW | Address of the write event |
| wr_data | output | DW | Data of the write event |

## Verification
The closing edge of a combined pulse can coincide with a loss of qualification. The read-enable pin may drop, or the supply flag may fall, in the same sampled cycles as the width counter reaches its limit. The bench provokes this with directed pulses that drop `oe_n` or `pwr_good` partway through a long pulse. It also uses random pulses whose widths straddle `MIN_LOW`. It judges each pulse by counting events at the output against a bench function of width, read-enable level and lockout state. It checks the captured address and data against the values that were deliberately changed mid-pulse.

// File: rtl/wsf_pkg.sv
package wsf_pkg;
  // Control pins bundled for the synchroniser
  typedef struct packed {
    logic pg;   // supply good, active high
    logic oe;   // read enable pin level (1 = not driving)
    logic we;   // write strobe pin level
    logic ce;   // chip select pin level
  } ctl_pins_t;

  localparam ctl_pins_t CTL_IDLE = '{pg: 1'b0, oe: 1'b1, we: 1'b1, ce: 1'b1};
endpackage

// File: rtl/wsf_sync.sv
module wsf_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/wsf_por_timer.sv
module wsf_por_timer #(
  parameter int POR_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst,
  input  logic pg_s,
  output logic ready
);
  localparam int CW = $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(POR_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !pg_s) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else begin
      if (cnt != LIMIT) cnt <= cnt + 1'b1;
      ready <= (cnt == LIMIT);
    end
  end
endmodule

// File: rtl/wsf_capture.sv
module wsf_capture #(
  parameter int AW = 19,
  parameter int DW = 8,
  parameter int MIN_LOW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_s,
  input  logic          we_s,
  input  logic          oe_s,
  input  logic          ready,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] data_s,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int CW = $clog2(MIN_LOW + 1) + 1;
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] CMIN = CW'(MIN_LOW);

  logic          act, act_q, armed, ok;
  logic [CW-1:0] width;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign act = !ce_s && !we_s;
  assign ok  = oe_s && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      armed    <= 1'b0;
      width    <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      act_q    <= act;
      wr_valid <= 1'b0;
      if (act && !act_q) begin
        // later falling edge: address is taken here
        armed  <= ok;
        width  <= CW'(1);
        addr_q <= addr_s;
        data_q <= data_s;
      end else if (act) begin
        if (!ok) armed <= 1'b0;
        if (width != CMAX) width <= width + 1'b1;
        data_q <= data_s;
      end else if (act_q) begin
        // first rising edge: data held from the last active sample
        armed <= 1'b0;
        if (armed && ok && width >= CMIN) begin
          wr_valid <= 1'b1;
          wr_addr  <= addr_q;
          wr_data  <= data_q;
        end
      end
    end
  end
endmodule

// File: rtl/wr_strobe_front.sv
module wr_strobe_front
  import wsf_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 8,
  parameter int MIN_LOW = 4,
  parameter int POR_CYCLES = 1250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          pwr_good,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int BW = AW + DW;

  ctl_pins_t     ctl_raw, ctl_s;
  logic [BW-1:0] bus_s;
  logic          ce_s, we_s, oe_s, pg_s, ready;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] data_s;

  assign ctl_raw = '{pg: pwr_good, oe: oe_n, we: we_n, ce: ce_n};

  wsf_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync_ctl (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
  );

  wsf_sync #(.WIDTH(BW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
    .clk(clk), .rst(rst), .d({addr, data}), .q(bus_s)
  );

  assign ce_s   = ctl_s.ce;
  assign we_s   = ctl_s.we;
  assign oe_s   = ctl_s.oe;
  assign pg_s   = ctl_s.pg;
  assign addr_s = bus_s[BW-1:DW];
  assign data_s = bus_s[DW-1:0];

  wsf_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .rst(rst), .pg_s(pg_s), .ready(ready)
  );

  wsf_capture #(.AW(AW), .DW(DW), .MIN_LOW(MIN_LOW)) u_cap (
    .clk(clk), .rst(rst),
    .ce_s(ce_s), .we_s(we_s), .oe_s(oe_s), .ready(ready),
    .addr_s(addr_s), .data_s(data_s),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: rtl/wsf_checker.sv
module wsf_checker #(
  parameter int MIN_LOW = 4
) (
  input logic clk,
  input logic rst,
  input logic ce_s,
  input logic we_s,
  input logic oe_s,
  input logic ready,
  input logic wr_valid
);
  logic        rst_q;
  logic [15:0] run, last_len;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      run      <= '0;
      last_len <= '0;
    end else if (!ce_s && !we_s) begin
      if (run != 16'hFFFF) run <= run + 1'b1;
    end else begin
      last_len <= run;
      run      <= '0;
    end
  end

  always_comb begin
    if (rst_q) assert_quiet_after_reset_R1: assert (!wr_valid);
  end

  assert_single_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);

  assert_min_width_R6: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (last_len >= 16'(MIN_LOW)));

  assert_oe_high_R3: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> $past(oe_s));

  assert_lockout_done_R8: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> $past(ready));
endmodule

bind wr_strobe_front wsf_checker #(.MIN_LOW(MIN_LOW)) u_chk (
  .clk(clk), .rst(rst), .ce_s(ce_s), .we_s(we_s), .oe_s(oe_s),
  .ready(ready), .wr_valid(wr_valid)
);

// File: tb/tb_wr_strobe_front.sv
module tb_wr_strobe_front;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int MIN_LOW = 4;
  localparam int POR = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, pwr_good = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0, fails = 0;
  int ev_n = 0;
  logic [AW-1:0] ev_a;
  logic [DW-1:0] ev_d;

  always #2 clk = ~clk;

  wr_strobe_front #(.AW(AW), .DW(DW), .MIN_LOW(MIN_LOW), .POR_CYCLES(POR)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .data(data), .pwr_good(pwr_good),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (!rst && wr_valid) begin
      ev_n++;
      ev_a = wr_addr;
      ev_d = wr_data;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_write(bit oe_hi, int len, bit locked);
    return oe_hi && !locked && (len >= MIN_LOW);
  endfunction

  task automatic pulse(bit ce_first, bit ce_rel_first, int len, logic [AW-1:0] a,
                       logic [DW-1:0] d, bit oe_hi, bit drop_oe, bit drop_pg);
    @(negedge clk);
    oe_n = oe_hi; addr = ~a; data = ~d;
    if (ce_first) ce_n = 1'b0; else we_n = 1'b0;
    repeat (2) @(negedge clk);
    if (ce_first) we_n = 1'b0; else ce_n = 1'b0;
    addr = a;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) begin addr = ~a; data = d; end
      if (i == len / 2 && drop_oe) oe_n = 1'b0;
      if (i == len / 2 && drop_pg) pwr_good = 1'b0;
    end
    if (ce_rel_first) ce_n = 1'b1; else we_n = 1'b1;
    data = ~d; addr = a ^ 8'h5A;
    repeat (2) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic run_case(string req, bit cf, bit crf, int len, logic [AW-1:0] a,
                          logic [DW-1:0] d, bit oe_hi, bit drop_oe, bit drop_pg, bit expect_wr);
    int n0 = ev_n;
    pulse(cf, crf, len, a, d, oe_hi, drop_oe, drop_pg);
    chk(req, ev_n - n0, int'(expect_wr));
    if (expect_wr && ev_n - n0 == 1) begin
      chk({req, " R4 addr"}, int'(ev_a), int'(a));
      chk({req, " R5 data"}, int'(ev_d), int'(d));
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", int'(wr_valid), 0);

    // supply not good
    run_case("R7 supply low", 1, 1, 6, 8'h11, 8'h22, 1, 0, 0, 0);

    // lockout window right after supply rise
    pwr_good = 1'b1;
    run_case("R8 inside lockout", 0, 0, 6, 8'h33, 8'h44, 1, 0, 0, 0);
    repeat (POR + 10) @(negedge clk);
    run_case("R8 after lockout R2", 0, 0, 6, 8'h35, 8'h46, 1, 0, 0, 1);

    // strobe orderings for address and data capture
    run_case("R4 ce falls first", 1, 0, 5, 8'hA1, 8'hB1, 1, 0, 0, 1);
    run_case("R4 we falls first", 0, 1, 5, 8'hA2, 8'hB2, 1, 0, 0, 1);
    run_case("R5 ce rises first", 0, 1, 7, 8'hA3, 8'hB3, 1, 0, 0, 1);
    run_case("R5 we rises first", 1, 0, 7, 8'hA4, 8'hB4, 1, 0, 0, 1);

    // glitch threshold
    run_case("R6 one short", 1, 1, MIN_LOW - 1, 8'hC0, 8'hD0, 1, 0, 0, 0);
    run_case("R6 exact width R9", 1, 1, MIN_LOW, 8'hC1, 8'hD1, 1, 0, 0, 1);
    run_case("R6 single cycle", 0, 0, 1, 8'hC2, 8'hD2, 1, 0, 0, 0);

    // read enable inhibit
    run_case("R3 oe low throughout", 1, 1, 6, 8'hE0, 8'hF0, 0, 0, 0, 0);
    run_case("R3 oe drop mid pulse", 1, 0, 8, 8'hE1, 8'hF1, 1, 1, 0, 0);

    // supply drop during pulse
    run_case("R10 supply drop", 0, 1, 8, 8'hE2, 8'hF2, 1, 0, 1, 0);
    pwr_good = 1'b1;
    run_case("R10 relocked", 1, 1, 6, 8'hE3, 8'hF3, 1, 0, 0, 0);
    repeat (POR + 10) @(negedge clk);
    run_case("R10 recovered R2", 1, 1, 6, 8'hE4, 8'hF4, 1, 0, 0, 1);

    // random pulses
    void'($urandom(32'd1234));
    for (int k = 0; k < 40; k++) begin
      bit cf = 1'($urandom);
      bit crf = 1'($urandom);
      int len = 1 + int'($urandom % 8);
      bit oe_hi = ($urandom % 5) != 0;
      logic [AW-1:0] a = AW'($urandom);
      logic [DW-1:0] d = DW'($urandom);
      run_case("R2 random R9", cf, crf, len, a, d, oe_hi, 0, 0, exp_write(oe_hi, len, 1'b0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule